// File: doc/BRIEF.md
# SPI Master Packet Transfer Engine

This block is a register-programmed SPI master. It moves a programmed number of packets between its internal transmit and receive FIFOs and the serial pins. Packets are 1 to 8 bits long. Software fills the transmit FIFO through a valid/ready stream. It writes a packet count into the block-size register, sets up the command register and launches the transfer with the start bit. The engine produces SCLK in SPI mode 0 at a fixed division of the system clock. It drives one of four chip-select lines and counts packets in a status register. When the last packet finishes, it raises a sticky ready flag.

Received packets leave through a second valid/ready stream. On both streams a beat moves only when valid and ready are both high in the same cycle. The transmit side holds `tx_ready` low while its FIFO is full. The receive side keeps `rx_data` stable while `rx_valid` is high and `rx_ready` is low. The serial side cannot stall, so a packet that arrives while the receive FIFO is full is dropped. Software clears the ready flag by writing a one to it. A start request made while the flag is still set does not launch anything.

Top module: `spi_pkt_engine`

## Requirements
- R1: After reset, the registers read as follows.
  - Command register (address 0) reads 0x03C00007.
  - Block-size register (address 1) and status register (address 2) read 0.
  - `sclk` is low, `cs_line` is 4'b1111, `rx_valid` is low and `tx_ready` is high.
- R2: SPI mode 0 operation.
  - SCLK idles low and each half period lasts HALF_DIV system cycles.
  - MOSI changes only on falling SCLK edges, and MISO is sampled on rising edges.
  - With command bit 16 clear, bits go out and come in most significant bit first.
- R3: Transfer length and completion.
  - The block-size register holds the packet count minus one.
  - The 16-bit packet counter (status bits 15:0) clears at start and steps once per packet.
  - The ready flag (status bit 30) sets exactly 2·L·HALF_DIV·N+1 cycles after the edge that captures the start write, for N packets of L bits.
  - The count then equals block size plus one, and the start bit (command bit 31) reads back 0.
- R4: The ready flag is cleared by writing 1 to status bit 30. A start write made while the flag is set is ignored: the start bit reads 0, SCLK stays low and the count is unchanged.
- R5: With transmit enable (command bit 11) clear, MOSI carries all ones and the transmit FIFO is not drained.
- R6: With receive enable (command bit 12) clear, no packet enters the receive FIFO.
- R7: With command bit 16 set, bits go out and come in least significant bit first.
- R8: The packet length field (command bits 4:0) holds the length minus one, up to 8 bits. Shorter packets are right-aligned in the byte, on both the transmit and the receive side.
- R9: Hardware chip-select framing.
  - Command bits 27:26 select one of four lines, and bits 25:22 give each line's inactive level.
  - The selected line is driven to the inverse of its inactive level while a transfer is busy.
  - All other lines stay at their inactive level.
- R10: When command bit 21 is set, the selected line follows command bit 20 at all times, in place of hardware framing.
- R11: Stream rules.
  - `tx_ready` is low exactly when FIFO_DEPTH entries are waiting.
  - `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.
- R12: Writes to the command or block-size register during a transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 block size, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| tx_data | input | PKT_W | Transmit stream data |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit FIFO has room |
| rx_data | output | PKT_W | Receive stream data |
| rx_valid | output | 1 | Receive FIFO holds a packet |
| rx_ready | input | 1 | Consumer accepts the packet |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select line levels |

## Verification
A start write is captured on one clock edge, and the engine registers it once before SCLK begins. The ready flag therefore becomes visible 2·L·HALF_DIV·N+1 edges later. The bench samples status in the cycle just before that and in the cycle it is due, so an early or late flag is caught. Chip-select and software override levels follow the register and are checked one edge after the write. Serial data is checked by a bench slave that captures MOSI on rising SCLK and shifts a pattern onto MISO on falling SCLK. Received packets are read from the stream only after the ready flag is seen.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

  localparam int NCS   = 4;
  localparam int CNT_W = 16;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_CMD  = 2'd0,
    ADDR_BLK  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;

  localparam int B_GO     = 31;
  localparam int B_SEL    = 26;
  localparam int B_POL    = 22;
  localparam int B_SWCS   = 21;
  localparam int B_SWVAL  = 20;
  localparam int B_LSBF   = 16;
  localparam int B_RXEN   = 12;
  localparam int B_TXEN   = 11;
  localparam int B_READY  = 30;

  typedef struct packed {
    logic       go;
    logic [1:0] sel;
    logic [3:0] pol;
    logic       sw_cs;
    logic       sw_val;
    logic       lsb_first;
    logic       rx_en;
    logic       tx_en;
    logic [4:0] len;
  } cmd_t;

  localparam logic [REG_W-1:0] CMD_RESET = 32'h03C0_0007;

  function automatic logic [REG_W-1:0] cmd_pack(cmd_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_GO]            = c.go;
    w[B_SEL+:2]        = c.sel;
    w[B_POL+:4]        = c.pol;
    w[B_SWCS]          = c.sw_cs;
    w[B_SWVAL]         = c.sw_val;
    w[B_LSBF]          = c.lsb_first;
    w[B_RXEN]          = c.rx_en;
    w[B_TXEN]          = c.tx_en;
    w[4:0]             = c.len;
    return w;
  endfunction

  function automatic cmd_t cmd_unpack(logic [REG_W-1:0] w);
    cmd_t c;
    c.go        = w[B_GO];
    c.sel       = w[B_SEL+:2];
    c.pol       = w[B_POL+:4];
    c.sw_cs     = w[B_SWCS];
    c.sw_val    = w[B_SWVAL];
    c.lsb_first = w[B_LSBF];
    c.rx_en     = w[B_RXEN];
    c.tx_en     = w[B_TXEN];
    c.len       = w[4:0];
    return c;
  endfunction

endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R11: occupancy never passes the depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R11: a waiting output word is held until taken
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/spi_pkt_shifter.sv
module spi_pkt_shifter #(
  parameter int PKT_W = 8,
  parameter int HALF  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       more,
  input  logic [PKT_W-1:0]           load_data,
  input  logic [$clog2(PKT_W)-1:0]   last_idx,
  input  logic                       lsb_first,
  input  logic                       miso,
  output logic                       sclk,
  output logic                       mosi,
  output logic                       load,
  output logic                       pkt_done,
  output logic [PKT_W-1:0]           rx_word,
  output logic                       active
);
  localparam int IW = $clog2(PKT_W);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic             run;
  logic [PW-1:0]    ph;
  logic             sclk_q;
  logic [IW-1:0]    bitcnt;
  logic [PKT_W-1:0] tx_sr, rx_sr;
  logic             edge_now, rise, fall;
  logic [IW-1:0]    rx_idx;

  assign edge_now = run && (ph == PW'(HALF - 1));
  assign rise     = edge_now && !sclk_q;
  assign fall     = edge_now && sclk_q;
  assign pkt_done = fall && (bitcnt == last_idx);
  assign load     = start || (pkt_done && more);
  assign rx_idx   = lsb_first ? bitcnt : (last_idx - bitcnt);

  assign sclk    = sclk_q;
  assign mosi    = lsb_first ? tx_sr[0] : tx_sr[last_idx];
  assign rx_word = rx_sr;
  assign active  = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= '0;
      sclk_q <= 1'b0;
      bitcnt <= '0;
      tx_sr  <= '1;
      rx_sr  <= '0;
    end else if (load) begin
      run    <= 1'b1;
      ph     <= '0;
      sclk_q <= 1'b0;
      bitcnt <= '0;
      tx_sr  <= load_data;
      rx_sr  <= '0;
    end else if (pkt_done) begin
      run    <= 1'b0;
      ph     <= '0;
      sclk_q <= 1'b0;
    end else if (run) begin
      if (edge_now) begin
        ph     <= '0;
        sclk_q <= ~sclk_q;
        if (rise) rx_sr[rx_idx] <= miso;
        if (fall) begin
          bitcnt <= bitcnt + IW'(1);
          tx_sr  <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        end
      end else begin
        ph <= ph + PW'(1);
      end
    end
  end

  // R2: bit counter stays inside the programmed packet
  a_r2_bit_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bitcnt <= last_idx));

  // R2: sclk returns low whenever shifting stops
  a_r2_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !sclk_q);

endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine
  import spi_pkt_pkg::*;
#(
  parameter int PKT_W      = 8,
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [PKT_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [PKT_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       cs_line
);
  localparam int IW = $clog2(PKT_W);
  localparam logic [4:0] LEN_MAX = 5'(PKT_W - 1);

  cmd_t             cmd_q;
  logic [CNT_W-1:0] blk_q, cnt_q;
  logic             busy_q, ready_q, start_q;

  logic             wr_cmd, wr_blk, wr_stat, go_ok;
  logic             more, load, pkt_done, sh_active;
  logic [IW-1:0]    last_idx;
  logic [PKT_W-1:0] txf_data, rx_word, load_data;
  logic             txf_valid, txf_pop, rx_push;
  logic             unused_rx_room;
  logic [13:0]      unused_wbits;

  assign wr_cmd  = reg_we && (reg_addr == ADDR_CMD);
  assign wr_blk  = reg_we && (reg_addr == ADDR_BLK);
  assign wr_stat = reg_we && (reg_addr == ADDR_STAT);
  assign go_ok   = wr_cmd && reg_wdata[B_GO] && !busy_q && !ready_q;
  assign more    = (cnt_q != blk_q);
  assign unused_wbits = {reg_wdata[29:28], reg_wdata[19:17], reg_wdata[15:13],
                         reg_wdata[10:5], reg_wdata[31]};

  assign last_idx  = (cmd_q.len >= LEN_MAX) ? IW'(PKT_W - 1) : cmd_q.len[IW-1:0];
  assign txf_pop   = load && cmd_q.tx_en;
  assign load_data = (cmd_q.tx_en && txf_valid) ? txf_data : '1;
  assign rx_push   = pkt_done && cmd_q.rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= cmd_unpack(CMD_RESET);
      blk_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= go_ok;
      if (wr_cmd && !busy_q) begin
        cmd_q    <= cmd_unpack(reg_wdata);
        cmd_q.go <= go_ok;
      end
      if (wr_blk && !busy_q) blk_q <= reg_wdata[CNT_W-1:0];
      if (go_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (pkt_done) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (!more) begin
          busy_q   <= 1'b0;
          cmd_q.go <= 1'b0;
        end
      end
      if (pkt_done && !more)                  ready_q <= 1'b1;
      else if (wr_stat && reg_wdata[B_READY]) ready_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CMD:  reg_rdata = cmd_pack(cmd_q);
      ADDR_BLK:  reg_rdata = {16'd0, blk_q};
      ADDR_STAT: reg_rdata = {1'b0, ready_q, 14'd0, cnt_q};
      default:   reg_rdata = '0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NCS; g++) begin : g_cs
      assign cs_line[g] = (cmd_q.sel != 2'(g)) ? cmd_q.pol[g]
                        : cmd_q.sw_cs          ? cmd_q.sw_val
                        : busy_q               ? ~cmd_q.pol[g]
                        :                        cmd_q.pol[g];
    end
  endgenerate

  spi_pkt_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(txf_valid), .out_ready(txf_pop), .out_data(txf_data)
  );

  spi_pkt_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(unused_rx_room), .in_data(rx_word),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  spi_pkt_shifter #(.PKT_W(PKT_W), .HALF(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(start_q), .more(more), .load_data(load_data),
    .last_idx(last_idx), .lsb_first(cmd_q.lsb_first), .miso(miso),
    .sclk(sclk), .mosi(mosi), .load(load), .pkt_done(pkt_done),
    .rx_word(rx_word), .active(sh_active)
  );

  // R4: no launch while the ready flag is still set
  a_r4_no_launch_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !busy_q) |=> !busy_q);

  // R3: the ready flag rises only as the transfer ends
  a_r3_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $fell(busy_q));

  // R3: the packet count never passes the block size while busy
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= blk_q));

  // R2: sclk idle low outside a transfer
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk);

  // R5: all ones on the line when transmit is off
  a_r5_ones_when_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sh_active && !cmd_q.tx_en) |-> mosi);

  // R12: configuration frozen during a transfer
  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(blk_q) && $stable(cmd_q.len)));

endmodule

// File: tb/tb_spi_pkt_engine.sv
module tb_spi_pkt_engine;
  localparam int PKT_W = 8;
  localparam int HALF  = 2;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'h03C0_0007;
  localparam logic [31:0] GO = 32'h8000_0000;
  localparam logic [31:0] RXE = 32'h0000_1000;
  localparam logic [31:0] TXE = 32'h0000_0800;
  localparam logic [31:0] LSBF = 32'h0001_0000;

  // tx byte, miso byte, lsb-first, expected byte at slave, expected rx
  localparam logic [32:0] VEC [4] = '{
    {8'hA5, 8'h3C, 1'b0, 8'hA5, 8'h3C},
    {8'h01, 8'hF0, 1'b1, 8'h80, 8'h0F},
    {8'h5A, 8'h81, 1'b0, 8'h5A, 8'h81},
    {8'hC8, 8'h12, 1'b1, 8'h13, 8'h48}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;
  logic sclk, mosi, miso;
  logic [3:0] cs_line;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [63:0] slave_pat = '1;
  logic [63:0] slave_rx = '0;
  int fcnt = 0;
  int base_f = 0;

  always #4 clk = ~clk;

  spi_pkt_engine #(.PKT_W(PKT_W), .HALF_DIV(HALF), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_line(cs_line)
  );

  always @(posedge sclk) slave_rx <= {slave_rx[62:0], mosi};
  always @(negedge sclk) fcnt <= fcnt + 1;
  always_comb begin
    int d;
    d = (fcnt - base_f) & 63;
    miso = slave_pat[63 - d];
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=finished", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    tx_valid = 1'b1; tx_data = b;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    while (!rx_valid) @(negedge clk);
    b = rx_data; rx_ready = 1'b1;
    @(posedge clk); #1;
    rx_ready = 1'b0;
  endtask

  task automatic clear_ready();
    wr(2'd2, 32'h4000_0000);
  endtask

  // start write then check the ready flag one cycle early and on time
  task automatic go_timed(input string req, input logic [31:0] c, input int t);
    logic [31:0] s;
    base_f = fcnt;
    wr(2'd0, c | GO);
    repeat (t - 1) @(posedge clk);
    @(negedge clk); rd(2'd2, s);
    chk({req, " ready early"}, s[30], 1'b0);
    @(posedge clk); @(negedge clk); rd(2'd2, s);
    chk({req, " ready due"}, s[30], 1'b1);
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    s = '0;
    for (int k = 0; k < 4000 && !s[30]; k++) begin
      @(negedge clk); rd(2'd2, s);
    end
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0] b;
    logic [7:0] first;
    int n;
    logic hi;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk("R1 cmd", r, 32'h03C0_0007);
    rd(2'd1, r); chk("R1 blk", r, 0);
    rd(2'd2, r); chk("R1 status", r, 0);
    chk("R1 pins", {sclk, cs_line, rx_valid, tx_ready}, {1'b0, 4'hF, 1'b0, 1'b1});

    // R2 R7 R3: vector table of single-packet transfers
    wr(2'd1, 32'd0);
    for (int i = 0; i < 4; i++) begin
      push(VEC[i][32:25]);
      slave_pat = {VEC[i][24:17], 56'hFF_FFFF_FFFF_FFFF};
      go_timed("R3", BASE | TXE | RXE | (VEC[i][16] ? LSBF : 32'd0), 2*8*HALF*1 + 1);
      chk(VEC[i][16] ? "R7 mosi order" : "R2 mosi order", slave_rx[7:0], VEC[i][15:8]);
      pop(b);
      chk(VEC[i][16] ? "R7 rx order" : "R2 rx order", b, VEC[i][7:0]);
      rd(2'd2, r); chk("R3 count", r[15:0], 1);
      rd(2'd0, r); chk("R3 go cleared", r[31], 1'b0);
      clear_ready();
    end

    // R3 two packets
    wr(2'd1, 32'd1);
    push(8'h12); push(8'h34);
    slave_pat = {8'hC3, 8'h5E, 48'hFFFF_FFFF_FFFF};
    go_timed("R3 two", BASE | TXE | RXE, 2*8*HALF*2 + 1);
    chk("R2 two mosi", slave_rx[15:0], 16'h1234);
    rd(2'd2, r); chk("R3 two count", r[15:0], 2);
    pop(b); chk("R3 rx0", b, 8'hC3);
    pop(b); chk("R3 rx1", b, 8'h5E);

    // R4 start ignored while ready still set
    wr(2'd0, BASE | TXE | GO);
    hi = 1'b0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); hi = hi | sclk; end
    chk("R4 no sclk", hi, 1'b0);
    rd(2'd0, r); chk("R4 go reads 0", r[31], 1'b0);
    rd(2'd2, r); chk("R4 count kept", r[15:0], 2);
    clear_ready();
    rd(2'd2, r); chk("R4 w1c", r[30], 1'b0);

    // R5 receive only: ones on mosi, tx FIFO kept
    wr(2'd1, 32'd0);
    push(8'h77);
    slave_pat = {8'h96, 56'hFF_FFFF_FFFF_FFFF};
    go_timed("R5", BASE | RXE, 2*8*HALF + 1);
    chk("R5 mosi ones", slave_rx[7:0], 8'hFF);
    pop(b); chk("R5 rx", b, 8'h96);
    clear_ready();

    // R6 transmit only: nothing received; R5 byte still queued
    go_timed("R6", BASE | TXE, 2*8*HALF + 1);
    chk("R5 kept byte sent", slave_rx[7:0], 8'h77);
    repeat (3) @(negedge clk);
    chk("R6 no rx push", rx_valid, 1'b0);
    clear_ready();

    // R8 4-bit packets
    push(8'h0B);
    slave_pat = {4'h6, 60'hFFF_FFFF_FFFF_FFFF};
    go_timed("R8", (BASE & ~32'h1F) | 32'd3 | TXE | RXE, 2*4*HALF + 1);
    chk("R8 mosi", slave_rx[3:0], 4'hB);
    pop(b); chk("R8 rx", b, 8'h06);
    clear_ready();

    // R9 hardware framing on line 2 (active high), R12 writes while busy
    wr(2'd0, 32'h0800_0000 | 32'h02C0_0000 | 32'd7 | TXE);
    @(negedge clk); chk("R9 idle cs", cs_line, 4'b1011);
    push(8'hAA);
    wr(2'd0, 32'h0800_0000 | 32'h02C0_0000 | 32'd7 | TXE | GO);
    repeat (6) @(negedge clk);
    chk("R9 active cs", cs_line, 4'b1111);
    wr(2'd1, 32'd5);
    wr(2'd0, BASE & ~32'h1F | 32'd3);
    wait_ready();
    chk("R9 released cs", cs_line, 4'b1011);
    chk("R9 data", slave_rx[7:0], 8'hAA);
    rd(2'd1, r); chk("R12 blk kept", r, 0);
    rd(2'd0, r); chk("R12 cmd kept", r[4:0], 5'd7);
    clear_ready();

    // R10 software chip-select on line 0
    wr(2'd0, BASE | 32'h0020_0000);
    @(negedge clk); chk("R10 sw low", cs_line, 4'b1110);
    wr(2'd0, BASE | 32'h0030_0000);
    @(negedge clk); chk("R10 sw high", cs_line, 4'b1111);

    // R11 stream back-pressure
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    @(negedge clk); chk("R11 tx full", tx_ready, 1'b0);
    wr(2'd1, 32'(DEPTH - 1));
    slave_pat = {8'h3E, 56'hFF_FFFF_FFFF_FFFF};
    base_f = fcnt;
    wr(2'd0, BASE | TXE | RXE | GO);
    wait_ready();
    chk("R11 tx drained", tx_ready, 1'b1);
    rd(2'd2, r); chk("R3 full count", r[15:0], 16'(DEPTH));
    first = rx_data;
    repeat (5) @(negedge clk);
    chk("R11 rx held", {rx_valid, rx_data}, {1'b1, first});
    chk("R11 rx first", first, 8'h3E);
    n = 0;
    for (int i = 0; i < DEPTH; i++) begin pop(b); n++; end
    @(negedge clk);
    chk("R11 rx drained", {rx_valid, 8'(n)}, {1'b0, 8'(DEPTH)});
    clear_ready();

    report();
    $finish;
  end
endmodule